// File: doc/BRIEF.md
# Dual Down-Counting Timer

The block contains two independent down counters that share one register window on a simple memory-mapped bus. The bus has a byte address, a write strobe, write data and combinational read data. Every access is a full 32-bit word. The word index (the address with its two low bits dropped) picks a timer and a register within it. Indices 0 to 5 belong to timer 0, and indices 6 to 11 belong to timer 1 after six is subtracted. Every index from 12 upward is outside the window.

Each timer is a small state machine with three named states:

- **ST_IDLE**: the counter is stopped.
- **ST_COUNT**: the counter decrements once per clock.
- **ST_DONE**: a one-shot timer has expired and holds at zero.

The transitions are:

- **start**: a control write with enable set moves ST_IDLE to ST_COUNT, and does the same from ST_DONE.
- **stop**: a control write with enable clear moves ST_COUNT or ST_DONE to ST_IDLE.
- **restart**: a control write with enable set, or a load write while enabled, moves ST_COUNT or ST_DONE to ST_COUNT and reloads the counter.
- **reload**: a periodic expiry keeps the timer in ST_COUNT.
- **finish**: a one-shot expiry moves ST_COUNT to ST_DONE.

An expiry is the counter standing at zero in ST_COUNT with no restart or stop write in that cycle. Each timer drives its own level interrupt line.

Top module: `dual_dn_timer`

## Requirements
- R1: After reset, all twelve words of the window read zero and both interrupt lines are low.
- R2: Word indices 0 to 5 address timer 0 and indices 6 to 11 address timer 1. Within a timer the word offsets are: 0 current count, 1 load value, 2 background load, 3 control (bit0 enable, bit1 interrupt enable, bit2 one-shot), 4 raw status (bit0), 5 masked status (bit0). A write to one timer leaves the other unchanged.
- R3: A word index of 12 or more reads as zero, and a write to it changes no register.
- R4: A control write with bit0 set loads the counter from the load value at that clock edge. The counter then decrements by one per clock.
- R5: A control write with bit0 clear freezes the counter at the value it held just before that edge.
- R6: A load write always stores the value. If the timer is enabled, the same edge also reloads the counter with that value. If it is disabled, the counter is left alone.
- R7: A background load write sets both the background load and the load value. The count in progress is not disturbed, and the new value is used at the next reload.
- R8: On an expiry the raw status bit is set. A periodic timer reloads the load value at the same edge, so it runs with a period of load+1 cycles.
- R9: On an expiry a one-shot timer holds its counter at zero, keeps its enable bit set and does not expire again.
- R10: Writing raw status with bit0 set clears it, and writing it with bit0 clear has no effect. An expiry at the same edge as a clearing write leaves the bit set.
- R11: Masked status reads as raw status AND interrupt enable. Writes to the masked status and current-count words are ignored.
- R12: Each timer's interrupt line equals its raw status AND its interrupt enable, one edge after the write or expiry that changes either.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (8) | Byte address of the access |
| bus_we | input | 1 | Write strobe, one word per cycle |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for bus_addr, combinational |
| irq | output | N_TMR (2) | Level interrupt, one line per timer |

## Verification
Read data is combinational from registered state, so a write shows up in the read data and on the interrupt line one edge after it is taken. The counter value is due L−(n mod (L+1)) after the starting edge, where n counts the edges since that edge. The bench counts clock edges and records the edge index at which each write lands. It computes every expected count from that edge distance at the moment it queues the expectation, and it samples at the falling edge, after all register updates have settled. The corner case of an expiry colliding with a clear is set up by waiting for the exact edge count before issuing the write.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;

    localparam int REGS_PER_TMR = 6;

    localparam logic [2:0] OFF_VALUE  = 3'd0;
    localparam logic [2:0] OFF_LOAD   = 3'd1;
    localparam logic [2:0] OFF_BGLOAD = 3'd2;
    localparam logic [2:0] OFF_CTRL   = 3'd3;
    localparam logic [2:0] OFF_RAW    = 3'd4;
    localparam logic [2:0] OFF_MASK   = 3'd5;

    localparam int CTRL_W = 3;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_DONE  = 2'd2
    } tmr_state_e;

    // bit0 enable, bit1 interrupt enable, bit2 one-shot
    typedef struct packed {
        logic oneshot;
        logic irq_en;
        logic enable;
    } tmr_ctrl_t;

endpackage

// File: rtl/dtmr_decode.sv
module dtmr_decode
    import dtmr_pkg::*;
#(
    parameter int N_TMR = 2,
    parameter int IDX_W = 6
) (
    input  logic [IDX_W-1:0] word_idx,
    output logic [N_TMR-1:0] tmr_sel,
    output logic [2:0]       reg_off,
    output logic             in_range
);
    localparam int N_WORDS = N_TMR * REGS_PER_TMR;

    int unsigned widx;

    always_comb begin
        widx     = 32'(word_idx);
        in_range = (widx < N_WORDS);
        reg_off  = 3'(widx % REGS_PER_TMR);
        for (int i = 0; i < N_TMR; i++) begin
            tmr_sel[i] = in_range && ((widx / REGS_PER_TMR) == i);
        end
    end

endmodule

// File: rtl/dtmr_unit.sv
module dtmr_unit
    import dtmr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        reg_off,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);
    tmr_state_e        state_q, state_d;
    tmr_ctrl_t         ctrl_q;
    logic [DATA_W-1:0] count_q, load_q, bgload_q;
    logic              raw_q;

    logic wr_ctrl, wr_load, wr_bg, wr_raw;
    logic start_wr, restart, halt_wr, expire;

    assign wr_ctrl  = wr_en && (reg_off == OFF_CTRL);
    assign wr_load  = wr_en && (reg_off == OFF_LOAD);
    assign wr_bg    = wr_en && (reg_off == OFF_BGLOAD);
    assign wr_raw   = wr_en && (reg_off == OFF_RAW);

    assign start_wr = wr_ctrl && wdata[0];
    assign restart  = start_wr || (wr_load && ctrl_q.enable);
    assign halt_wr  = wr_ctrl || restart;
    assign expire   = (state_q == ST_COUNT) && (count_q == '0) && !halt_wr;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_wr) state_d = ST_COUNT;
            end
            ST_COUNT: begin
                if (wr_ctrl && !wdata[0])      state_d = ST_IDLE;
                else if (restart)              state_d = ST_COUNT;
                else if (expire && ctrl_q.oneshot) state_d = ST_DONE;
            end
            ST_DONE: begin
                if (wr_ctrl)      state_d = wdata[0] ? ST_COUNT : ST_IDLE;
                else if (restart) state_d = ST_COUNT;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers driven by the state machine
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            count_q  <= '0;
            load_q   <= '0;
            bgload_q <= '0;
            raw_q    <= 1'b0;
        end else begin
            if (wr_ctrl) ctrl_q <= tmr_ctrl_t'(wdata[CTRL_W-1:0]);
            if (wr_load || wr_bg) load_q <= wdata;
            if (wr_bg) bgload_q <= wdata;

            if (start_wr)                          count_q <= load_q;
            else if (wr_load && ctrl_q.enable)     count_q <= wdata;
            else if (expire && !ctrl_q.oneshot)    count_q <= load_q;
            else if (state_q == ST_COUNT && !wr_ctrl && count_q != '0)
                count_q <= count_q - 1'b1;

            if (expire)                   raw_q <= 1'b1;
            else if (wr_raw && wdata[0])  raw_q <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        rdata = '0;
        unique case (reg_off)
            OFF_VALUE:  rdata = count_q;
            OFF_LOAD:   rdata = load_q;
            OFF_BGLOAD: rdata = bgload_q;
            OFF_CTRL:   rdata = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
            OFF_RAW:    rdata = {{(DATA_W-1){1'b0}}, raw_q};
            OFF_MASK:   rdata = {{(DATA_W-1){1'b0}}, raw_q & ctrl_q.irq_en};
            default:    rdata = '0;
        endcase
    end

    assign irq = raw_q && ctrl_q.irq_en;

    a_r4_decrement: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COUNT && count_q != '0 && !wr_en) |=> (count_q == $past(count_q) - 1'b1));

    a_r8_periodic_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COUNT && count_q == '0 && !wr_en && !ctrl_q.oneshot)
        |=> (count_q == $past(load_q) && raw_q));

    a_r9_oneshot_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE && !wr_en) |=> (count_q == '0 && state_q == ST_DONE && ctrl_q.enable));

    a_r5_stopped_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !wr_en) |=> $stable(count_q));

    a_r10_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_raw && wdata[0] && !(state_q == ST_COUNT && count_q == '0)) |=> !raw_q);

endmodule

// File: rtl/dual_dn_timer.sv
module dual_dn_timer
    import dtmr_pkg::*;
#(
    parameter int N_TMR  = 2,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [N_TMR-1:0]  irq
);
    localparam int IDX_W   = ADDR_W - 2;
    localparam int N_WORDS = N_TMR * REGS_PER_TMR;

    logic [IDX_W-1:0]  word_idx;
    logic [N_TMR-1:0]  tmr_sel;
    logic [2:0]        reg_off;
    logic              in_range;
    logic [DATA_W-1:0] unit_rd [N_TMR];

    assign word_idx = bus_addr[ADDR_W-1:2];

    dtmr_decode #(.N_TMR(N_TMR), .IDX_W(IDX_W)) u_decode (
        .word_idx (word_idx),
        .tmr_sel  (tmr_sel),
        .reg_off  (reg_off),
        .in_range (in_range)
    );

    for (genvar g = 0; g < N_TMR; g++) begin : g_tmr
        dtmr_unit #(.DATA_W(DATA_W)) u_unit (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (bus_we && tmr_sel[g]),
            .reg_off (reg_off),
            .wdata   (bus_wdata),
            .rdata   (unit_rd[g]),
            .irq     (irq[g])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < N_TMR; i++) begin
            if (tmr_sel[i]) bus_rdata = bus_rdata | unit_rd[i];
        end
    end

    a_r2_single_timer: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tmr_sel));

    a_r3_outside_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(word_idx) >= N_WORDS) |-> (bus_rdata == '0 && !in_range));

endmodule

// File: tb/dual_dn_timer_bench.sv
module dual_dn_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  irq;

    always #10 clk = ~clk;   // 50 MHz

    dual_dn_timer u_dual_dn_timer (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    logic [31:0] q_exp[$];
    int          q_kind[$];
    string       q_tag[$];
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    // monitor: pops expectations and compares against the design
    initial begin
        forever begin
            wait (q_exp.size() > 0);
            #2;
            begin
                logic [31:0] e, a;
                int k;
                string t;
                e = q_exp.pop_front();
                k = q_kind.pop_front();
                t = q_tag.pop_front();
                a = (k == 0) ? bus_rdata : {31'b0, irq[k-1]};
                n_cmp++;
                if (a !== e) begin
                    n_bad++;
                    $display("FAIL %s: actual %h expected %h", t, a, e);
                end
            end
        end
    end

    task automatic push(input logic [31:0] e, input int k, input string t);
        q_exp.push_back(e); q_kind.push_back(k); q_tag.push_back(t);
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b0;
        push(e, 0, t);
    endtask

    // periodic count model: L - (n mod (L+1)), n = edges since base
    task automatic rd_per(input logic [7:0] a, input int L, input int base, input string t);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b0;
        push(32'(L - ((cyc - base) % (L + 1))), 0, t);
    endtask

    task automatic chk_irq(input int idx, input bit e, input string t);
        @(negedge clk);
        push({31'b0, e}, idx + 1, t);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, output int w);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(posedge clk);
        #1;
        bus_we = 1'b0;
        w = cyc;
    endtask

    task automatic wait_edges_since(input int base, input int n);
        while (cyc - base < n) begin
            @(posedge clk); #1;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp + 1, n_bad);
            $finish;
        end
    end

    initial begin
        int w, w0, w1, wd, wt, wb, wl, wo, frozen;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        for (int i = 0; i < 12; i++) rd(8'(i * 4), 32'h0, "R1 reset word");
        chk_irq(0, 1'b0, "R1 irq0 low");
        chk_irq(1, 1'b0, "R1 irq1 low");

        // R6 disabled load only stores; R2 decode
        wr(8'h04, 32'd16, w);
        rd(8'h00, 32'd0,  "R6 disabled load leaves count");
        rd(8'h04, 32'd16, "R6 load stored");
        rd(8'h1C, 32'd0,  "R2 timer1 untouched");
        wr(8'h1C, 32'h55, w);
        rd(8'h1C, 32'h55, "R2 timer1 load");
        rd(8'h04, 32'd16, "R2 timer0 load kept");

        // R3 out of range
        wr(8'h30, 32'hFFFF_FFFF, w);
        wr(8'hFC, 32'hFFFF_FFFF, w);
        rd(8'h30, 32'd0, "R3 idx12 reads zero");
        rd(8'hFC, 32'd0, "R3 idx63 reads zero");
        rd(8'h04, 32'd16, "R3 timer0 unchanged");
        rd(8'h1C, 32'h55, "R3 timer1 unchanged");

        // R4 start and count down, timer0 periodic L=40
        wr(8'h04, 32'd40, w);
        wr(8'h0C, 32'h3, w0);
        rd_per(8'h00, 40, w0, "R4 count after start");
        rd_per(8'h00, 40, w0, "R4 decrement");
        rd_per(8'h00, 40, w0, "R4 decrement");

        // R8 expiry and reload
        wait_edges_since(w0, 43);
        rd_per(8'h00, 40, w0, "R8 reloaded count");
        rd(8'h10, 32'd1, "R8 raw set");
        rd(8'h14, 32'd1, "R11 masked set");
        chk_irq(0, 1'b1, "R12 irq0 high");

        // R10 write zero has no effect
        wr(8'h10, 32'd0, w);
        rd(8'h10, 32'd1, "R10 zero write keeps raw");

        // R11 masking and read-only words
        wr(8'h0C, 32'h1, w1);
        rd(8'h14, 32'd0, "R11 masked off");
        chk_irq(0, 1'b0, "R12 irq0 masked");
        rd(8'h10, 32'd1, "R11 raw kept");
        wr(8'h00, 32'h1234, w);
        rd_per(8'h00, 40, w1, "R11 value write ignored");
        wr(8'h14, 32'h1, w);
        rd(8'h14, 32'd0, "R11 masked write ignored");
        wr(8'h10, 32'h1, w);
        rd(8'h10, 32'd0, "R10 clear raw");

        // R5 stop freezes the count
        wr(8'h0C, 32'h0, wd);
        frozen = 40 - ((wd - 1 - w1) % 41);
        repeat (5) @(posedge clk);
        rd(8'h00, 32'(frozen), "R5 count frozen");
        rd(8'h0C, 32'd0, "R5 ctrl cleared");

        // R7 background load on timer1
        wr(8'h1C, 32'd20, w);
        wr(8'h24, 32'h3, wt);
        repeat (3) @(posedge clk);
        wr(8'h20, 32'd8, wb);
        rd_per(8'h18, 20, wt, "R7 count undisturbed");
        rd(8'h20, 32'd8, "R7 bg stored");
        rd(8'h1C, 32'd8, "R7 load updated");
        wait_edges_since(wt, 23);
        rd_per(8'h18, 8, wt + 21, "R7 new value at reload");
        rd(8'h28, 32'd1, "R8 timer1 raw");
        chk_irq(1, 1'b1, "R12 irq1 high");

        // R6 enabled load restarts
        wr(8'h1C, 32'd30, wl);
        rd_per(8'h18, 30, wl, "R6 enabled load restarts");

        // R10 expiry beats clear at the same edge
        wr(8'h28, 32'h1, w);
        rd(8'h28, 32'd0, "R10 raw cleared");
        while (cyc < wl + 30) begin @(posedge clk); #1; end
        wr(8'h28, 32'h1, w);
        rd(8'h28, 32'd1, "R10 expiry wins over clear");
        chk_irq(1, 1'b1, "R12 irq1 after collision");

        // R9 one-shot on timer0
        wr(8'h04, 32'd3, w);
        wr(8'h0C, 32'h7, wo);
        repeat (10) @(posedge clk);
        rd(8'h00, 32'd0, "R9 holds zero");
        rd(8'h10, 32'd1, "R9 raw set");
        rd(8'h0C, 32'd7, "R9 enable kept");
        chk_irq(0, 1'b1, "R12 irq0 one-shot");
        wr(8'h10, 32'h1, w);
        repeat (8) @(posedge clk);
        rd(8'h10, 32'd0, "R9 no second expiry");
        rd(8'h00, 32'd0, "R9 still zero");

        wait (q_exp.size() == 0);
        #5;
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule